// File: doc/BRIEF.md
# Accumulator ALU with Nibble Carry Flags

This block is the combinational arithmetic and logic unit of an 8-bit accumulator machine. Each evaluation takes the accumulator, a second operand, a 4-bit operation code and the four incoming condition flags. It produces the new accumulator value, the new flags and a write strobe that tells the register file whether to store the result. Each operation sets, clears, computes or keeps each flag according to its own rule.

Every add or subtract also computes a carry or borrow out of the low nibble. This half-carry feeds the decimal adjust operation. Decimal adjust fixes the accumulator after a BCD add or subtract, using the subtract, half-carry and carry flags left by that operation. The block has no clock. The bench only paces its stimulus.

Flags travel as a 4-bit vector: bit 3 zero (Z), bit 2 subtract (N), bit 1 half-carry (H), bit 0 carry (C). Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 complement, 11 decimal adjust, 12 set carry, 13 complement carry. Codes 14 and 15 are unused.

Top module: `alu8_core`

## Requirements
- R1: Add (0) and add with carry (1) produce A+B(+C). Z follows the result and N clears. H is set when the low nibbles plus carry-in exceed 0xF. C is set when the full sum exceeds 0xFF.
- R2: Subtract (2) and subtract with borrow (3) produce A-B(-C). N sets, H marks a borrow out of the low nibble, C marks a borrow out of bit 7, and Z follows the result.
- R3: Compare (4) sets the flags exactly as subtract does, and drives writeEn low.
- R4: AND (5) clears N and C and sets H. OR (6) and XOR (7) clear N, H and C. In all three, Z follows the result.
- R5: Increment (8) adds one and decrement (9) subtracts one. Z follows the result. N clears for increment and sets for decrement. H reflects the low-nibble carry or borrow. C passes through unchanged.
- R6: Complement (10) inverts A and sets N and H. Z and C pass through unchanged.
- R7: Set carry (12) sets C and clears N and H. Complement carry (13) inverts C and clears N and H. Both keep Z and leave the result equal to A.
- R8: Decimal adjust (11) with N=0 adds 0x06 if H is set or the low nibble of A exceeds 9. It adds 0x60 and sets C if C is set or A exceeds 0x99. Otherwise C clears.
- R9: Decimal adjust with N=1 subtracts 0x06 if H is set and 0x60 if C is set. C is kept. For both directions, H clears, N is kept, and Z follows the adjusted result.
- R10: writeEn is high for every defined code except compare. Codes 14 and 15 drive writeEn low, return A and pass the flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accIn | input | 8 | Accumulator operand |
| operand | input | 8 | Second operand |
| opCode | input | 4 | Operation select |
| flagsIn | input | 4 | Incoming flags {Z,N,H,C} |
| result | output | 8 | Operation result |
| flagsOut | output | 4 | New flags {Z,N,H,C} |
| writeEn | output | 1 | Store the result into the accumulator |

## Verification
The bench builds the block with its default data width of 8. Decimal adjust and the 0x99 limit are defined only for two 4-bit digits. At this width the vectors reach the full-byte wrap of add and increment and the byte borrow of subtract and compare. They also reach both nibble boundaries and every branch of the two decimal-adjust directions, including the case where the adjustment wraps the result to zero and sets Z.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CPL = 4'd10,
    OP_DAA = 4'd11,
    OP_SCF = 4'd12,
    OP_CCF = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOT,
    SEL_ADJ,
    SEL_ACC
  } resSel_e;

  typedef enum logic [1:0] {
    FK_KEEP,
    FK_CLR,
    FK_SET,
    FK_CALC
  } flagMode_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } aluFlags_t;

  typedef struct packed {
    resSel_e   resSel;
    logic      subtract;
    logic      useCarry;
    logic      unitOperand;
    flagMode_e zMode;
    flagMode_e nMode;
    flagMode_e hMode;
    flagMode_e cMode;
    logic      cInvert;
    logic      writeEn;
  } aluStrobe_t;

  function automatic logic applyMode(flagMode_e m, logic keepVal, logic calcVal);
    case (m)
      FK_CLR:  return 1'b0;
      FK_SET:  return 1'b1;
      FK_CALC: return calcVal;
      default: return keepVal;
    endcase
  endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         subtract,
  output logic [W-1:0] sum,
  output logic         halfOut,
  output logic         carryOut
);
  localparam int NIB = W / 2;

  logic [NIB:0] lowPart;
  logic [W:0]   fullPart;

  always_comb begin
    if (subtract) begin
      lowPart  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
      fullPart = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    end else begin
      lowPart  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
      fullPart = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
  end

  assign sum      = fullPart[W-1:0];
  assign halfOut  = lowPart[NIB];
  assign carryOut = fullPart[W];
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic         nIn,
  input  logic         hIn,
  input  logic         cIn,
  output logic [W-1:0] adjusted,
  output logic         carryOut
);
  localparam int          NIB      = W / 2;
  localparam logic [W-1:0] LOW_SIX  = W'(6);
  localparam logic [W-1:0] HIGH_SIX = W'(6) << NIB;
  localparam logic [W-1:0] LIMIT    = (W'(9) << NIB) | W'(9);
  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);

  logic [W-1:0] adj;

  always_comb begin
    adj      = '0;
    carryOut = cIn;
    if (nIn) begin
      if (hIn) adj = adj | LOW_SIX;
      if (cIn) adj = adj | HIGH_SIX;
      adjusted = acc - adj;
    end else begin
      if (hIn || (acc[NIB-1:0] > DIGIT_MAX)) adj = adj | LOW_SIX;
      if (cIn || (acc > LIMIT)) begin
        adj      = adj | HIGH_SIX;
        carryOut = 1'b1;
      end else begin
        carryOut = 1'b0;
      end
      adjusted = acc + adj;
    end
  end
endmodule

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0]  opCode,
  output aluStrobe_t  strobe
);
  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    strobe = '{resSel: SEL_ACC, subtract: 1'b0, useCarry: 1'b0, unitOperand: 1'b0,
               zMode: FK_KEEP, nMode: FK_KEEP, hMode: FK_KEEP, cMode: FK_KEEP,
               cInvert: 1'b0, writeEn: 1'b0};
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        strobe.resSel   = SEL_SUM;
        strobe.subtract = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        strobe.useCarry = (op == OP_ADC) || (op == OP_SBC);
        strobe.zMode    = FK_CALC;
        strobe.nMode    = strobe.subtract ? FK_SET : FK_CLR;
        strobe.hMode    = FK_CALC;
        strobe.cMode    = FK_CALC;
        strobe.writeEn  = (op != OP_CMP);
      end
      OP_AND: begin
        strobe.resSel  = SEL_AND;
        strobe.zMode   = FK_CALC;
        strobe.nMode   = FK_CLR;
        strobe.hMode   = FK_SET;
        strobe.cMode   = FK_CLR;
        strobe.writeEn = 1'b1;
      end
      OP_OR, OP_XOR: begin
        strobe.resSel  = (op == OP_OR) ? SEL_OR : SEL_XOR;
        strobe.zMode   = FK_CALC;
        strobe.nMode   = FK_CLR;
        strobe.hMode   = FK_CLR;
        strobe.cMode   = FK_CLR;
        strobe.writeEn = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobe.resSel      = SEL_SUM;
        strobe.subtract    = (op == OP_DEC);
        strobe.unitOperand = 1'b1;
        strobe.zMode       = FK_CALC;
        strobe.nMode       = (op == OP_DEC) ? FK_SET : FK_CLR;
        strobe.hMode       = FK_CALC;
        strobe.writeEn     = 1'b1;
      end
      OP_CPL: begin
        strobe.resSel  = SEL_NOT;
        strobe.nMode   = FK_SET;
        strobe.hMode   = FK_SET;
        strobe.writeEn = 1'b1;
      end
      OP_DAA: begin
        strobe.resSel  = SEL_ADJ;
        strobe.zMode   = FK_CALC;
        strobe.hMode   = FK_CLR;
        strobe.cMode   = FK_CALC;
        strobe.writeEn = 1'b1;
      end
      OP_SCF, OP_CCF: begin
        strobe.nMode   = FK_CLR;
        strobe.hMode   = FK_CLR;
        strobe.cMode   = (op == OP_SCF) ? FK_SET : FK_KEEP;
        strobe.cInvert = (op == OP_CCF);
        strobe.writeEn = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] operand,
  input  aluFlags_t    flagsIn,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] result,
  output aluFlags_t    flagsOut
);
  logic [W-1:0] addB;
  logic [W-1:0] sumVal;
  logic [W-1:0] adjVal;
  logic         sumHalf;
  logic         sumCarry;
  logic         adjCarry;
  logic         carryCalc;
  logic         cKept;

  assign addB = strobe.unitOperand ? W'(1) : operand;

  alu8_adder #(.W(W)) uAdder (
    .a        (accIn),
    .b        (addB),
    .cin      (strobe.useCarry & flagsIn.c),
    .subtract (strobe.subtract),
    .sum      (sumVal),
    .halfOut  (sumHalf),
    .carryOut (sumCarry)
  );

  alu8_decadj #(.W(W)) uDecAdj (
    .acc      (accIn),
    .nIn      (flagsIn.n),
    .hIn      (flagsIn.h),
    .cIn      (flagsIn.c),
    .adjusted (adjVal),
    .carryOut (adjCarry)
  );

  always_comb begin
    case (strobe.resSel)
      SEL_SUM: result = sumVal;
      SEL_AND: result = accIn & operand;
      SEL_OR:  result = accIn | operand;
      SEL_XOR: result = accIn ^ operand;
      SEL_NOT: result = ~accIn;
      SEL_ADJ: result = adjVal;
      default: result = accIn;
    endcase
  end

  assign carryCalc = (strobe.resSel == SEL_ADJ) ? adjCarry : sumCarry;
  assign cKept     = flagsIn.c ^ strobe.cInvert;

  always_comb begin
    flagsOut.z = applyMode(strobe.zMode, flagsIn.z, result == '0);
    flagsOut.n = applyMode(strobe.nMode, flagsIn.n, 1'b0);
    flagsOut.h = applyMode(strobe.hMode, flagsIn.h, sumHalf);
    flagsOut.c = applyMode(strobe.cMode, cKept, carryCalc);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        opCode,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut,
  output logic              writeEn
);
  aluStrobe_t strobe;
  aluFlags_t  flagsNew;

  alu8_ctrl uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu8_datapath #(.W(DATA_W)) uData (
    .accIn    (accIn),
    .operand  (operand),
    .flagsIn  (aluFlags_t'(flagsIn)),
    .strobe   (strobe),
    .result   (result),
    .flagsOut (flagsNew)
  );

  assign flagsOut = flagsNew;
  assign writeEn  = strobe.writeEn;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] operand,
  input logic [3:0]        opCode,
  input logic [3:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flagsOut,
  input logic              writeEn
);
  always_comb begin
    if (opCode == 4'd4) begin
      AST_CMP_NO_WRITE: assert (!writeEn) else $error("compare wrote result"); // R3
    end
    if (opCode == 4'd4 && accIn == operand) begin
      AST_CMP_EQUAL: assert (flagsOut[3] && !flagsOut[0]) else $error("equal compare flags"); // R3
    end
    if (opCode >= 4'd5 && opCode <= 4'd7) begin
      AST_LOGIC_CARRY_CLR: assert (!flagsOut[0] && !flagsOut[2]) else $error("logic flags"); // R4
    end
    if (opCode == 4'd8 || opCode == 4'd9) begin
      AST_STEP_KEEP_CARRY: assert (flagsOut[0] == flagsIn[0]) else $error("step carry"); // R5
    end
    if (opCode == 4'd10) begin
      AST_CPL_FLAGS: assert (flagsOut[2] && flagsOut[1] && flagsOut[3] == flagsIn[3]) else $error("cpl flags"); // R6
    end
    if (opCode == 4'd12) begin
      AST_SCF_FLAGS: assert (flagsOut[0] && !flagsOut[1] && !flagsOut[2] && result == accIn) else $error("scf"); // R7
    end
    if (opCode == 4'd11) begin
      AST_DAA_HALF_CLR: assert (!flagsOut[1] && flagsOut[2] == flagsIn[2]) else $error("daa h/n"); // R9
    end
    if (opCode >= 4'd14) begin
      AST_RSV_PASS: assert (!writeEn && flagsOut == flagsIn && result == accIn) else $error("reserved"); // R10
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic [7:0] accIn, operand, result;
  logic [3:0] opCode, flagsIn, flagsOut;
  logic       writeEn;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  alu8_core dut (
    .accIn(accIn), .operand(operand), .opCode(opCode), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut), .writeEn(writeEn)
  );

  task automatic run(input string req, input logic [3:0] op, input logic [7:0] a,
                     input logic [7:0] b, input logic [3:0] f, input logic [7:0] expRes,
                     input logic [3:0] expFlags, input logic expWe);
    @(posedge clk);
    accIn = a; operand = b; opCode = op; flagsIn = f;
    @(negedge clk);
    checks++;
    if (result !== expRes || flagsOut !== expFlags || writeEn !== expWe) begin
      errors++;
      $display("FAIL %s op=%0d: got res=%h flags=%h we=%b expected res=%h flags=%h we=%b",
               req, op, result, flagsOut, writeEn, expRes, expFlags, expWe);
    end
  endtask

  task automatic testReset;
    run("R10", 4'd14, 8'h00, 8'h00, 4'h0, 8'h00, 4'h0, 1'b0);
    run("R10", 4'd15, 8'h5C, 8'h11, 4'hA, 8'h5C, 4'hA, 1'b0);
  endtask

  task automatic testAdd; // R1
    run("R1", 4'd0, 8'h3A, 8'hC6, 4'h0, 8'h00, 4'hB, 1'b1);
    run("R1", 4'd0, 8'h12, 8'h34, 4'h1, 8'h46, 4'h0, 1'b1);
    run("R1", 4'd1, 8'h0F, 8'h00, 4'h1, 8'h10, 4'h2, 1'b1);
    run("R1", 4'd1, 8'hFF, 8'h00, 4'h1, 8'h00, 4'hB, 1'b1);
  endtask

  task automatic testSub; // R2
    run("R2", 4'd2, 8'h10, 8'h01, 4'h0, 8'h0F, 4'h6, 1'b1);
    run("R2", 4'd2, 8'h05, 8'h10, 4'h0, 8'hF5, 4'h5, 1'b1);
    run("R2", 4'd3, 8'h10, 8'h00, 4'h1, 8'h0F, 4'h6, 1'b1);
  endtask

  task automatic testCmp; // R3
    run("R3", 4'd4, 8'h42, 8'h42, 4'h0, 8'h00, 4'hC, 1'b0);
    run("R3", 4'd4, 8'h20, 8'h21, 4'h0, 8'hFF, 4'h7, 1'b0);
  endtask

  task automatic testLogic; // R4
    run("R4", 4'd5, 8'hF0, 8'h0F, 4'hF, 8'h00, 4'hA, 1'b1);
    run("R4", 4'd6, 8'h00, 8'h00, 4'hF, 8'h00, 4'h8, 1'b1);
    run("R4", 4'd7, 8'h5A, 8'hFF, 4'hF, 8'hA5, 4'h0, 1'b1);
  endtask

  task automatic testStep; // R5
    run("R5", 4'd8, 8'h0F, 8'h77, 4'h1, 8'h10, 4'h3, 1'b1);
    run("R5", 4'd8, 8'hFF, 8'h00, 4'h0, 8'h00, 4'hA, 1'b1);
    run("R5", 4'd9, 8'h10, 8'h00, 4'h0, 8'h0F, 4'h6, 1'b1);
    run("R5", 4'd9, 8'h01, 8'h00, 4'h1, 8'h00, 4'hD, 1'b1);
  endtask

  task automatic testCpl; // R6
    run("R6", 4'd10, 8'h35, 8'h00, 4'h9, 8'hCA, 4'hF, 1'b1);
    run("R6", 4'd10, 8'hFF, 8'h00, 4'h0, 8'h00, 4'h6, 1'b1);
  endtask

  task automatic testCarryOps; // R7
    run("R7", 4'd12, 8'h44, 8'h00, 4'h6, 8'h44, 4'h1, 1'b1);
    run("R7", 4'd13, 8'h44, 8'h00, 4'hF, 8'h44, 4'h8, 1'b1);
    run("R7", 4'd13, 8'h44, 8'h00, 4'h0, 8'h44, 4'h1, 1'b1);
  endtask

  task automatic testDaaAdd; // R8
    run("R8", 4'd11, 8'h3C, 8'h00, 4'h0, 8'h42, 4'h0, 1'b1);
    run("R8", 4'd11, 8'h9A, 8'h00, 4'h0, 8'h00, 4'h9, 1'b1);
    run("R8", 4'd11, 8'h12, 8'h00, 4'h2, 8'h18, 4'h0, 1'b1);
    run("R8", 4'd11, 8'h45, 8'h00, 4'h0, 8'h45, 4'h0, 1'b1);
  endtask

  task automatic testDaaSub; // R9
    run("R9", 4'd11, 8'h0F, 8'h00, 4'h6, 8'h09, 4'h4, 1'b1);
    run("R9", 4'd11, 8'hF5, 8'h00, 4'h5, 8'h95, 4'h5, 1'b1);
    run("R9", 4'd11, 8'h00, 8'h00, 4'h4, 8'h00, 4'hC, 1'b1);
  endtask

  initial begin
    accIn = '0; operand = '0; opCode = 4'd14; flagsIn = '0;
    testReset();
    testAdd();
    testSub();
    testCmp();
    testLogic();
    testStep();
    testCpl();
    testCarryOps();
    testDaaAdd();
    testDaaSub();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule